// File: doc/BRIEF.md
# Write-Protected Byte-Wide Static Memory Port

This block models a 2048-byte static memory behind an asynchronous-style pin interface, with every pin sampled on a system clock. The interface has three active-low controls: chip select, output enable and write enable. It also has an 11-bit address, and an 8-bit data bus that is split into an input, an output and an output-drive qualifier. A read drives the selected byte while the part is selected, output enable is low and write enable is high.

A write window exists while both chip select and write enable are low. It therefore opens at whichever of the two falls last and closes at whichever rises first. The block keeps a write only if the window was sampled open on at least two consecutive edges, the address held still the whole time, and enough recovery time passed since the previous window. A write that breaks either of the last two rules is dropped and sets a sticky error flag.

A lockout input from a supply monitor overrides everything. While it is high, all pins are ignored and the outputs float. An open window is abandoned, and the stored bytes are kept.

Top module: `nvsram_port`

## Requirements
- R1: After reset, `dout_en` is 0, `dout` is 0, and both `rec_err` and `addr_err` are 0.
- R2: At a clock edge where `cs_n`=0, `oe_n`=0, `we_n`=1 and `lock`=0, the byte stored at `addr` appears on `dout` after that edge, with `dout_en`=1. At any other edge, both outputs become 0 after the edge.
- R3: A window is sampled open at an edge with `cs_n`=0, `we_n`=0 and `lock`=0. The byte is stored at the edge where the window is first sampled closed. The address is the one held during the window, and the data is the `din` sampled at the last open edge.
- R4: A window works the same whether write enable or chip select is the later signal to fall, and whether write enable or chip select is the first to rise.
- R5: A window sampled open on only one edge stores nothing.
- R6: After a window closes, the next window may open only after at least `REC_CYC` further edges with `we_n`=1. A window that opens sooner is dropped and sets `rec_err`, which stays at 1 until reset.
- R7: If `addr` differs from its value at the opening edge at any later open edge, the write is dropped and `addr_err` is set, staying at 1 until reset.
- R8: A falling `we_n` while the outputs are driven turns the drive off after the edge that samples it low.
- R9: While `lock`=1, `dout_en` is 0 and `dout` is 0, and no pin activity writes the memory or changes the error flags.
- R10: A window still open when `lock` rises is abandoned without a write. Bytes stored before a lockout read back unchanged after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| lock | input | 1 | Supply-fail lockout, active high |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 11 | Byte address |
| din | input | 8 | Write data from the bus |
| dout | output | 8 | Read data toward the bus |
| dout_en | output | 1 | Bus drive qualifier, 1 = driving |
| rec_err | output | 1 | Sticky recovery-time violation |
| addr_err | output | 1 | Sticky address-change-in-window violation |

## Verification
Writes are tried with windows framed by write enable and windows framed by chip select. Comparing the two shows that the window follows the overlap of the two signals and not either signal alone. A one-edge window is set against a two-edge window to pin down the minimum length. Back-to-back windows and an address that moves mid-window are read back afterwards, which confirms that each was dropped and that its sticky flag was set. Reads are interrupted by a falling write enable, by a high output enable and by lockout, to confirm the outputs go quiet. A write attempted under lockout, and a window cut short by lockout, are both read back afterwards to show the memory kept its prior contents.

// File: rtl/nvsram_pkg.sv
package nvsram_pkg;
    localparam int ADDR_W  = 11;
    localparam int DATA_W  = 8;
    localparam int REC_CYC = 2;

    typedef struct packed {
        logic open;     // window sampled open on previous edge
        logic long_ok;  // at least two open edges seen
        logic bad;      // window doomed (recovery or address fault)
    } win_flags_t;

    function automatic logic read_cond(input logic lk, input logic cs,
                                       input logic oe, input logic we);
        return !lk && !cs && !oe && we;
    endfunction

    function automatic logic win_cond(input logic lk, input logic cs,
                                      input logic we);
        return !lk && !cs && !we;
    endfunction
endpackage

// File: rtl/nvsram_wwin.sv
module nvsram_wwin
    import nvsram_pkg::*;
#(
    parameter int AW  = ADDR_W,
    parameter int DW  = DATA_W,
    parameter int REC = REC_CYC
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          lock,
    input  logic          cs_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          rec_err,
    output logic          addr_err
);
    localparam int CW = $clog2(REC + 1);
    localparam logic [CW-1:0] REC_MAX = CW'(REC);

    win_flags_t    st;
    logic [AW-1:0] a_q;
    logic [DW-1:0] d_q;
    logic [CW-1:0] rec_cnt;
    logic          open_now;

    assign open_now = win_cond(lock, cs_n, we_n);
    assign wr_en    = st.open && !lock && !open_now && st.long_ok && !st.bad;
    assign wr_addr  = a_q;
    assign wr_data  = d_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= '0;
            a_q      <= '0;
            d_q      <= '0;
            rec_cnt  <= REC_MAX;
            rec_err  <= 1'b0;
            addr_err <= 1'b0;
        end else if (lock) begin
            st <= '0;
        end else if (open_now && !st.open) begin
            st.open    <= 1'b1;
            st.long_ok <= 1'b0;
            st.bad     <= (rec_cnt < REC_MAX);
            a_q        <= addr;
            d_q        <= din;
            if (rec_cnt < REC_MAX) rec_err <= 1'b1;
        end else if (open_now) begin
            st.long_ok <= 1'b1;
            d_q        <= din;
            if (addr != a_q) begin
                st.bad   <= 1'b1;
                addr_err <= 1'b1;
            end
        end else if (st.open) begin
            st      <= '0;
            rec_cnt <= '0;
        end else if (we_n && rec_cnt < REC_MAX) begin
            rec_cnt <= rec_cnt + 1'b1;
        end
    end

    // R6
    rec_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        rec_err |=> rec_err);
    // R7
    addr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        addr_err |=> addr_err);
    // R3
    commit_src_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> $past(!cs_n && !we_n && !lock));
    // R9
    lock_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
        lock |-> !wr_en);
endmodule

// File: rtl/nvsram_array.sv
module nvsram_array
    import nvsram_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            rd_data  <= rd_en ? mem[rd_addr] : '0;
        end
    end

    // R2
    quiet_data_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |-> rd_data == '0);
endmodule

// File: rtl/nvsram_port.sv
module nvsram_port
    import nvsram_pkg::*;
#(
    parameter int AW  = ADDR_W,
    parameter int DW  = DATA_W,
    parameter int REC = REC_CYC
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          lock,
    input  logic          cs_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          dout_en,
    output logic          rec_err,
    output logic          addr_err
);
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;
    logic          rd_en;

    assign rd_en = read_cond(lock, cs_n, oe_n, we_n);

    nvsram_wwin #(.AW(AW), .DW(DW), .REC(REC)) u_win (
        .clk(clk), .rst(rst), .lock(lock), .cs_n(cs_n), .we_n(we_n),
        .addr(addr), .din(din), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rec_err(rec_err), .addr_err(addr_err)
    );

    nvsram_array #(.AW(AW), .DW(DW)) u_mem (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(addr),
        .rd_data(dout), .rd_valid(dout_en)
    );

    // R9
    lock_float_chk: assert property (@(posedge clk) disable iff (rst)
        lock |=> !dout_en);
    // R8
    we_fall_off_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(we_n) |-> ##0 1'b1 ##1 !dout_en);
endmodule

// File: tb/sim_nvsram_port.sv
module sim_nvsram_port;
    localparam int REC = 2;

    logic        clk = 1'b0;
    logic        rst, lock, cs_n, oe_n, we_n;
    logic [10:0] addr;
    logic [7:0]  din;
    logic [7:0]  dout;
    logic        dout_en, rec_err, addr_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    nvsram_port #(.REC(REC)) u0 (
        .clk(clk), .rst(rst), .lock(lock), .cs_n(cs_n), .oe_n(oe_n),
        .we_n(we_n), .addr(addr), .din(din), .dout(dout),
        .dout_en(dout_en), .rec_err(rec_err), .addr_err(addr_err)
    );

    task automatic step(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        cs_n = 1; oe_n = 1; we_n = 1;
    endtask

    // full write with enough recovery afterwards
    task automatic wr(logic [10:0] a, logic [7:0] d, int len);
        addr = a; din = d; cs_n = 0; we_n = 0;
        step(len);
        we_n = 1;
        step();
        cs_n = 1;
        step(REC);
    endtask

    task automatic rd_chk(string req, logic [10:0] a, logic [7:0] exp);
        addr = a; cs_n = 0; oe_n = 0; we_n = 1;
        step();
        chk(req, {31'd0, dout_en}, 32'd1);
        chk(req, {24'd0, dout}, {24'd0, exp});
        idle();
        step();
    endtask

    task automatic t_reset();
        chk("R1 dout_en", {31'd0, dout_en}, 0);
        chk("R1 dout", {24'd0, dout}, 0);
        chk("R1 rec_err", {31'd0, rec_err}, 0);
        chk("R1 addr_err", {31'd0, addr_err}, 0);
    endtask

    task automatic t_basic();
        wr(11'h005, 8'h3C, 2);
        wr(11'h7FF, 8'hA5, 3);
        rd_chk("R2/R3 addr 005", 11'h005, 8'h3C);
        rd_chk("R2/R3 addr 7FF", 11'h7FF, 8'hA5);
        addr = 11'h005; cs_n = 0; oe_n = 1; step();
        chk("R2 oe high no drive", {31'd0, dout_en}, 0);
        chk("R2 oe high dout zero", {24'd0, dout}, 0);
        idle(); step();
    endtask

    task automatic t_ce_framed();
        // R4: WE falls first, CS frames the window
        addr = 11'h100; din = 8'h77; we_n = 0; cs_n = 1; step();
        cs_n = 0; step(2);
        cs_n = 1; step();
        we_n = 1; step(REC);
        rd_chk("R4 cs framed", 11'h100, 8'h77);
    endtask

    task automatic t_short();
        wr(11'h200, 8'h11, 2);
        wr(11'h200, 8'h99, 1);
        rd_chk("R5 single-edge dropped", 11'h200, 8'h11);
    endtask

    task automatic t_we_fall();
        wr(11'h300, 8'h5A, 2);
        addr = 11'h300; cs_n = 0; oe_n = 0; we_n = 1; step();
        chk("R8 driving before", {31'd0, dout_en}, 1);
        din = 8'hEE; we_n = 0; step();
        chk("R8 drive off after we fall", {31'd0, dout_en}, 0);
        we_n = 1; oe_n = 1; step();
        cs_n = 1; step(REC);
        rd_chk("R5/R8 one-edge window no write", 11'h300, 8'h5A);
    endtask

    task automatic t_lock();
        wr(11'h400, 8'hC3, 2);
        lock = 1;
        addr = 11'h400; cs_n = 0; oe_n = 0; we_n = 1; step();
        chk("R9 no drive in lock", {31'd0, dout_en}, 0);
        chk("R9 dout zero in lock", {24'd0, dout}, 0);
        oe_n = 1; din = 8'h00; we_n = 0; step(3);
        addr = 11'h401; step();
        we_n = 1; step();
        cs_n = 1; step();
        chk("R9 flags untouched", {30'd0, rec_err, addr_err}, 0);
        lock = 0; step(REC);
        rd_chk("R10 kept over lock", 11'h400, 8'hC3);
        // window cut by lockout
        addr = 11'h400; din = 8'h44; cs_n = 0; we_n = 0; step(2);
        lock = 1; step();
        idle(); step();
        lock = 0; step(REC);
        rd_chk("R10 abandoned window", 11'h400, 8'hC3);
    endtask

    task automatic t_addr_move();
        wr(11'h500, 8'h12, 2);
        wr(11'h501, 8'h34, 2);
        chk("R7 flag clear before", {31'd0, addr_err}, 0);
        addr = 11'h500; din = 8'hFF; cs_n = 0; we_n = 0; step();
        addr = 11'h501; step();
        we_n = 1; step();
        cs_n = 1; step(REC);
        chk("R7 addr_err set", {31'd0, addr_err}, 1);
        rd_chk("R7 first addr kept", 11'h500, 8'h12);
        rd_chk("R7 second addr kept", 11'h501, 8'h34);
        step(2);
        chk("R7 addr_err sticky", {31'd0, addr_err}, 1);
    endtask

    task automatic t_recovery();
        chk("R6 flag clear before", {31'd0, rec_err}, 0);
        addr = 11'h600; din = 8'h21; cs_n = 0; we_n = 0; step(2);
        we_n = 1; step();
        addr = 11'h601; din = 8'h43; we_n = 0; step(2);
        we_n = 1; step();
        cs_n = 1; step(REC);
        chk("R6 rec_err set", {31'd0, rec_err}, 1);
        rd_chk("R6 first write kept", 11'h600, 8'h21);
        wr(11'h601, 8'h65, 2);
        rd_chk("R6 after gap ok", 11'h601, 8'h65);
        chk("R6 rec_err sticky", {31'd0, rec_err}, 1);
    endtask

    initial begin
        rst = 1; lock = 0; cs_n = 1; oe_n = 1; we_n = 1;
        addr = '0; din = '0;
        step(3);
        rst = 0;
        step();
        t_reset();
        t_basic();
        t_ce_framed();
        t_short();
        t_we_fall();
        t_lock();
        t_addr_move();
        t_recovery();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog: actual hung expected done");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures",
                 checks, fails);
        $finish;
    end
endmodule